// File: doc/BRIEF.md
# Serial Flash Write-Protect Gate

This block sits between the command decoder of a 512 KB serial NOR flash and its array sequencer. For every decoded command it decides whether the command may proceed. It tracks the write-enable latch and the deep power-down state. It turns the protection configuration bits into a protected address range. It also applies the status-register lock that the write-protect pin drives. The array sees only commands that this block accepts.

The protected range is either a whole number of 64 KB blocks or a small run of 4 KB sectors. It is anchored at the top or at the bottom of the array. Program and erase commands are checked against this range at the granularity of the data they would change. The complement-protect mode is not provided and behaves as if it were held at zero.

Each valid command produces a one-cycle accept or reject pulse on the clock after it is presented. The only exception is a command that arrives during deep power-down and is not the release command; such a command produces no pulse. An accepted modifying command stays outstanding until the array returns its completion strobe.

Top module: `flash_wp_gate`

## Requirements
- R1: After a synchronous reset, the accept and reject pulses are low, the write-enable latch is clear and the deep power-down flag is clear.
- R2: Command codes on `cmd_op_i` are 0 none, 1 write-enable, 2 write-disable, 3 read, 4 page program, 5 sector erase, 6 block erase, 7 chip erase, 8 status write, 9 security-register program/erase, 10 enter power-down, 11 release power-down. Codes 12 to 15 act like code 0. A valid command outside power-down gives exactly one of `acc_o` or `rej_o` high on the next cycle. Non-modifying codes are always accepted.
- R3: Write-enable sets the latch and write-disable clears it, each visible on the cycle after the command.
- R4: The modifying codes 4 to 9 are rejected while the latch is clear. A rejected modifying command clears the latch.
- R5: With sector mode off (`cfg_sec_i`=0), `cfg_bp_i` selects the protected block span. Code 000 protects nothing, 001 one block, 010 two blocks, 011 four blocks, and 1xx all eight blocks. `cfg_tb_i`=0 anchors the span at the top of the array and 1 at address 0.
- R6: With sector mode on, `cfg_bp_i` 001, 010 and 011 protect 4, 8 and 16 KB. Codes 100, 101 and 110 protect 32 KB and 111 protects the whole array. The span is anchored as in R5, and 000 protects nothing.
- R7: Page program and sector erase are rejected if the 4 KB sector holding `cmd_addr_i` is protected. Block erase is rejected if any byte of the 64 KB block holding the address is protected. Chip erase is rejected if any range is protected. Security-register commands are not checked against the range.
- R8: A status write is rejected when `cfg_srp_i` is 2'b01 (bit 0 set, bit 1 clear) and `wp_n_i` is low. With any other `cfg_srp_i` value the pin level has no effect.
- R9: An accepted modifying command becomes outstanding. `array_done_i` then clears the latch and the outstanding state. A modifying command presented while one is outstanding is rejected.
- R10: Enter power-down sets `dpd_o`. While it is set, every command except release produces no pulse and leaves the latch unchanged. Release clears `dpd_o` with an accept pulse and keeps the latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Command code (R2) |
| cmd_addr_i | input | ADDR_W (19) | Byte address of program or erase |
| cfg_sec_i | input | 1 | Sector-granular protection select |
| cfg_tb_i | input | 1 | Range anchor: 0 top, 1 bottom |
| cfg_bp_i | input | 3 | Protection span code |
| cfg_srp_i | input | 2 | Status lock mode; bit 0 is the pin-lock enable |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| array_done_i | input | 1 | Completion strobe from the array |
| acc_o | output | 1 | Command accepted pulse |
| rej_o | output | 1 | Command rejected pulse |
| wel_o | output | 1 | Write-enable latch state |
| dpd_o | output | 1 | Deep power-down state |

## Verification
The hardest state to reach from the ports is a rejection caused only by range overlap. To isolate it, the latch must be set, nothing may be outstanding and power-down must be off. The bench therefore issues a write-enable before every probe and returns a completion strobe after every accept, so each probe starts from the same clean state. It sweeps all 32 combinations of sector mode, anchor and span code. For each combination it tries program and sector erase in all 128 sectors, block erase in all 8 blocks, and chip erase. The expected verdict comes from byte bounds that the bench computes in kilobytes.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_WREN    = 4'd1,
    OP_WRDI    = 4'd2,
    OP_READ    = 4'd3,
    OP_PROG    = 4'd4,
    OP_SERASE  = 4'd5,
    OP_BERASE  = 4'd6,
    OP_CERASE  = 4'd7,
    OP_STWR    = 4'd8,
    OP_SECREG  = 4'd9,
    OP_DPD     = 4'd10,
    OP_RELEASE = 4'd11,
    OP_RSV12   = 4'd12,
    OP_RSV13   = 4'd13,
    OP_RSV14   = 4'd14,
    OP_RSV15   = 4'd15
  } wp_op_e;

  // Commands that change array or status contents and need the latch.
  function automatic logic is_modify(input wp_op_e op);
    unique case (op)
      OP_PROG, OP_SERASE, OP_BERASE, OP_CERASE, OP_STWR, OP_SECREG: is_modify = 1'b1;
      default: is_modify = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flash_wp_range.sv
// Turns the protection configuration into an inclusive sector-index range.
module flash_wp_range #(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16
) (
  input  logic                       sec_i,
  input  logic                       tb_i,
  input  logic [2:0]                 bp_i,
  output logic                       en_o,
  output logic [ADDR_W-SECT_W-1:0]   lo_o,
  output logic [ADDR_W-SECT_W-1:0]   hi_o
);
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam int NSECT  = 1 << SIDX_W;
  localparam int SPB    = 1 << (BLK_W - SECT_W);
  localparam logic [SIDX_W:0] FULL   = (SIDX_W+1)'(NSECT);
  localparam logic [SIDX_W:0] BLK1   = (SIDX_W+1)'(SPB);
  localparam logic [SIDX_W:0] ONE    = (SIDX_W+1)'(1);

  logic [SIDX_W:0] size;
  logic [SIDX_W:0] lo_w;
  logic [SIDX_W:0] hi_w;

  always_comb begin
    size = '0;
    if (!sec_i) begin
      unique casez (bp_i)
        3'b000:  size = '0;
        3'b001:  size = BLK1;
        3'b010:  size = BLK1 << 1;
        3'b011:  size = BLK1 << 2;
        default: size = FULL;
      endcase
    end else begin
      unique case (bp_i)
        3'b000:  size = '0;
        3'b001:  size = ONE;
        3'b010:  size = ONE << 1;
        3'b011:  size = ONE << 2;
        3'b111:  size = FULL;
        default: size = ONE << 3;
      endcase
    end
  end

  always_comb begin
    en_o = (size != '0);
    if (tb_i) begin
      lo_w = '0;
      hi_w = size - ONE;
    end else begin
      lo_w = FULL - size;
      hi_w = FULL - ONE;
    end
    lo_o = lo_w[SIDX_W-1:0];
    hi_o = hi_w[SIDX_W-1:0];
  end

  always_comb begin
    if (en_o) begin
      // R5
      range_order_chk: assert (lo_o <= hi_o);
    end
  end

endmodule

// File: rtl/flash_wp_overlap.sv
// Decides whether the data a command would change meets the protected range.
module flash_wp_overlap
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16
) (
  input  wp_op_e                     op_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       en_i,
  input  logic [ADDR_W-SECT_W-1:0]   lo_i,
  input  logic [ADDR_W-SECT_W-1:0]   hi_i,
  output logic                       hit_o
);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((1 << BLK_W) - 1);

  logic [ADDR_W-1:0] prot_lo_b;
  logic [ADDR_W-1:0] prot_hi_b;
  logic [ADDR_W-1:0] blk_lo_b;
  logic [ADDR_W-1:0] blk_hi_b;
  logic              in_range;
  logic              blk_meet;

  always_comb begin
    prot_lo_b = {lo_i, {SECT_W{1'b0}}};
    prot_hi_b = {hi_i, {SECT_W{1'b1}}} | SECT_MASK;
    blk_lo_b  = addr_i & ~BLK_MASK;
    blk_hi_b  = addr_i | BLK_MASK;
    in_range  = (addr_i >= prot_lo_b) && (addr_i <= prot_hi_b);
    blk_meet  = (prot_lo_b <= blk_hi_b) && (prot_hi_b >= blk_lo_b);
  end

  always_comb begin
    unique case (op_i)
      OP_PROG, OP_SERASE: hit_o = en_i && in_range;
      OP_BERASE:          hit_o = en_i && blk_meet;
      OP_CERASE:          hit_o = en_i;
      default:            hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_wp_ctrl.sv
// Latch, power-down and outstanding-command state; registered verdicts.
module flash_wp_ctrl
  import flash_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid_i,
  input  wp_op_e     op_i,
  input  logic       hit_i,
  input  logic [1:0] srp_i,
  input  logic       wp_n_i,
  input  logic       done_i,
  output logic       acc_q,
  output logic       rej_q,
  output logic       wel_q,
  output logic       dpd_q
);
  logic pend_q;
  logic mod_cmd;
  logic pin_lock;
  logic grant;

  always_comb begin
    mod_cmd  = is_modify(op_i);
    pin_lock = srp_i[0] && !srp_i[1] && !wp_n_i;
    grant    = wel_q && !pend_q && !hit_i && !((op_i == OP_STWR) && pin_lock);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      wel_q  <= 1'b0;
      dpd_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      if (done_i && pend_q) begin
        pend_q <= 1'b0;
        wel_q  <= 1'b0;
      end
      if (valid_i) begin
        if (dpd_q) begin
          if (op_i == OP_RELEASE) begin
            dpd_q <= 1'b0;
            acc_q <= 1'b1;
          end
        end else if (mod_cmd) begin
          if (grant) begin
            acc_q  <= 1'b1;
            pend_q <= 1'b1;
          end else begin
            rej_q <= 1'b1;
            wel_q <= 1'b0;
          end
        end else begin
          acc_q <= 1'b1;
          unique case (op_i)
            OP_WREN: wel_q <= 1'b1;
            OP_WRDI: wel_q <= 1'b0;
            OP_DPD:  dpd_q <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  // R2
  verdict_given_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && !dpd_q |=> (acc_q ^ rej_q));

  // R4
  no_latch_rej_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && !dpd_q && mod_cmd && !wel_q |=> rej_q && !wel_q);

  // R7
  range_rej_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && !dpd_q && hit_i |=> rej_q);

  // R8
  pin_lock_rej_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && !dpd_q && (op_i == OP_STWR) && srp_i == 2'b01 && !wp_n_i |=> rej_q);

  // R9
  busy_rej_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && !dpd_q && mod_cmd && pend_q |=> rej_q);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done_i && pend_q && !(valid_i && !dpd_q && op_i == OP_WREN) |=> !wel_q);

  // R10
  dpd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && dpd_q && (op_i != OP_RELEASE) && !done_i |=> !acc_q && !rej_q && $stable(wel_q) && dpd_q);

endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cfg_sec_i,
  input  logic              cfg_tb_i,
  input  logic [2:0]        cfg_bp_i,
  input  logic [1:0]        cfg_srp_i,
  input  logic              wp_n_i,
  input  logic              array_done_i,
  output logic              acc_o,
  output logic              rej_o,
  output logic              wel_o,
  output logic              dpd_o
);
  localparam int SIDX_W = ADDR_W - SECT_W;

  wp_op_e            op;
  logic              prot_en;
  logic [SIDX_W-1:0] prot_lo;
  logic [SIDX_W-1:0] prot_hi;
  logic              hit;

  assign op = wp_op_e'(cmd_op_i);

  flash_wp_range #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) range_i (
    .sec_i (cfg_sec_i),
    .tb_i  (cfg_tb_i),
    .bp_i  (cfg_bp_i),
    .en_o  (prot_en),
    .lo_o  (prot_lo),
    .hi_o  (prot_hi)
  );

  flash_wp_overlap #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) overlap_i (
    .op_i   (op),
    .addr_i (cmd_addr_i),
    .en_i   (prot_en),
    .lo_i   (prot_lo),
    .hi_i   (prot_hi),
    .hit_o  (hit)
  );

  flash_wp_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .valid_i (cmd_valid_i),
    .op_i    (op),
    .hit_i   (hit),
    .srp_i   (cfg_srp_i),
    .wp_n_i  (wp_n_i),
    .done_i  (array_done_i),
    .acc_q   (acc_o),
    .rej_q   (rej_o),
    .wel_q   (wel_o),
    .dpd_q   (dpd_o)
  );

endmodule

// File: tb/flash_wp_gate_tb_top.sv
module flash_wp_gate_tb_top;
  localparam logic [3:0] C_NONE = 4'd0, C_WREN = 4'd1, C_WRDI = 4'd2, C_READ = 4'd3,
                         C_PROG = 4'd4, C_SERASE = 4'd5, C_BERASE = 4'd6, C_CERASE = 4'd7,
                         C_STWR = 4'd8, C_SECREG = 4'd9, C_DPD = 4'd10, C_REL = 4'd11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [18:0] cmd_addr = '0;
  logic        cfg_sec = 1'b0, cfg_tb = 1'b0;
  logic [2:0]  cfg_bp = '0;
  logic [1:0]  cfg_srp = '0;
  logic        wp_n = 1'b1;
  logic        done = 1'b0;
  logic        acc, rej, wel, dpd;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_wp_gate dut_i (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .cfg_sec_i(cfg_sec), .cfg_tb_i(cfg_tb), .cfg_bp_i(cfg_bp), .cfg_srp_i(cfg_srp),
    .wp_n_i(wp_n), .array_done_i(done), .acc_o(acc), .rej_o(rej), .wel_o(wel), .dpd_o(dpd)
  );

  task automatic check(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // Present one command; on return the registered outputs reflect it.
  task automatic issue(input logic [3:0] op, input logic [18:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = C_NONE;
  endtask

  task automatic finish_cmd();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  // Protected byte bounds computed from kilobyte sizes.
  task automatic exp_bounds(output logic en, output int lo, output int hi);
    int kb;
    kb = 0;
    if (!cfg_sec) begin
      if (cfg_bp[2]) kb = 512;
      else if (cfg_bp == 3'd1) kb = 64;
      else if (cfg_bp == 3'd2) kb = 128;
      else if (cfg_bp == 3'd3) kb = 256;
    end else begin
      if (cfg_bp == 3'd7) kb = 512;
      else if (cfg_bp[2]) kb = 32;
      else if (cfg_bp == 3'd1) kb = 4;
      else if (cfg_bp == 3'd2) kb = 8;
      else if (cfg_bp == 3'd3) kb = 16;
    end
    en = (kb != 0);
    if (cfg_tb) begin lo = 0; hi = kb * 1024 - 1; end
    else begin lo = 524288 - kb * 1024; hi = 524287; end
  endtask

  task automatic probe(input logic [3:0] op, input logic [18:0] addr, input logic exp_hit,
                       input string tag);
    issue(C_WREN, '0);
    issue(op, addr);
    check(acc, !exp_hit, {tag, " accept"});
    check(rej, exp_hit, {tag, " reject"});
    if (acc) finish_cmd();
    check(wel, 1'b0, "R9/R4 latch clear after verdict");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic en;
    int lo, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(acc, 1'b0, "R1 acc"); check(rej, 1'b0, "R1 rej");
    check(wel, 1'b0, "R1 wel"); check(dpd, 1'b0, "R1 dpd");

    // R2 non-modifying codes accepted, reserved codes act as none
    issue(C_READ, '0); check(acc, 1'b1, "R2 read accepted");
    issue(4'd13, '0); check(acc, 1'b1, "R2 reserved accepted"); check(wel, 1'b0, "R2 reserved no latch");
    issue(C_REL, '0); check(acc, 1'b1, "R2 release outside power-down");

    // R3 latch set and clear
    issue(C_WREN, '0); check(wel, 1'b1, "R3 write-enable sets");
    issue(C_WRDI, '0); check(wel, 1'b0, "R3 write-disable clears");

    // R4 modifying codes rejected without latch
    for (int c = 4; c <= 9; c++) begin
      issue(4'(c), '0); check(rej, 1'b1, "R4 no latch reject");
    end
    issue(C_WREN, '0);
    issue(C_PROG, 19'h7FFFF); cfg_bp = 3'd7;
    finish_cmd();
    issue(C_WREN, '0);
    issue(C_PROG, 19'h00010); check(rej, 1'b1, "R7 all protected reject");
    check(wel, 1'b0, "R4 reject clears latch");

    // R7 security register ignores range
    issue(C_WREN, '0);
    issue(C_SECREG, '0); check(acc, 1'b1, "R7 security reg not range checked");
    finish_cmd();
    cfg_bp = 3'd0;

    // R8 pin lock on status write
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        cfg_srp = 2'(s); wp_n = p[0];
        issue(C_WREN, '0);
        issue(C_STWR, '0);
        check(rej, (s == 1) && (p == 0), "R8 status lock reject");
        check(acc, !((s == 1) && (p == 0)), "R8 status lock accept");
        if (acc) finish_cmd();
      end
    end
    cfg_srp = 2'd0; wp_n = 1'b1;

    // R9 outstanding command
    issue(C_WREN, '0);
    issue(C_PROG, 19'h12345); check(acc, 1'b1, "R9 first accepted");
    check(wel, 1'b1, "R9 latch held while outstanding");
    issue(C_SERASE, 19'h00000); check(rej, 1'b1, "R9 busy reject");
    issue(C_WREN, '0);
    finish_cmd(); check(wel, 1'b0, "R9 done clears latch");
    issue(C_WREN, '0);
    issue(C_CERASE, '0); check(acc, 1'b1, "R9 accepted after done");
    finish_cmd();

    // R10 power-down
    issue(C_WREN, '0);
    issue(C_DPD, '0); check(dpd, 1'b1, "R10 enter"); check(acc, 1'b1, "R10 enter accepted");
    issue(C_WRDI, '0); check(acc, 1'b0, "R10 ignored no accept");
    check(rej, 1'b0, "R10 ignored no reject"); check(wel, 1'b1, "R10 latch unchanged");
    issue(C_PROG, '0); check(acc | rej, 1'b0, "R10 program ignored");
    issue(C_REL, '0); check(acc, 1'b1, "R10 release accepted");
    check(dpd, 1'b0, "R10 release exits"); check(wel, 1'b1, "R10 latch preserved");
    issue(C_WRDI, '0);

    // R5 R6 R7 exhaustive range sweep
    for (int cfg = 0; cfg < 32; cfg++) begin
      cfg_sec = cfg[4]; cfg_tb = cfg[3]; cfg_bp = cfg[2:0];
      exp_bounds(en, lo, hi);
      for (int s = 0; s < 128; s++) begin
        int a;
        a = s * 4096 + ((s * 613) & 4095);
        probe(C_PROG, 19'(a), en && a >= lo && a <= hi,
              cfg_sec ? "R6 program sector" : "R5 program sector");
        probe(C_SERASE, 19'(a), en && a >= lo && a <= hi, "R7 sector erase");
      end
      for (int b = 0; b < 8; b++) begin
        int a, blo, bhi;
        a = b * 65536 + ((b * 4099) & 65535);
        blo = b * 65536; bhi = blo + 65535;
        probe(C_BERASE, 19'(a), en && lo <= bhi && hi >= blo, "R7 block erase");
      end
      probe(C_CERASE, '0, en, "R7 chip erase");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule